// File: doc/BRIEF.md
# Posted Interrupt Notification Drain

This block runs when a notification vector for user-level interrupts reaches a core. It takes the address of a posted-request descriptor from a configuration input. It then makes four memory accesses in a fixed order.

First it reads the descriptor's first byte, clears the outstanding-notification flag in bit 0, and writes the byte back. Next it reads the 64-bit posted-request word at descriptor offset 8 and writes zero to that word. Finally it ORs the fetched bits into a local pending-request register. Requests that were already pending in that register are kept.

After each merge, a pending-event output is re-evaluated from the register and a feature-enable input. A start pulse that arrives while a sequence is running is held and replayed once the running sequence completes.

Top module: `posted_notify_drain`

## Requirements
- R1: A start pulse sampled while idle makes the next cycle issue a byte read (mem_we=0, mem_wide=0) at address desc_base.
- R2: After the byte read is acknowledged, a byte write (mem_we=1, mem_wide=0) to desc_base follows. Its mem_wdata[7:0] is the byte that was read with bit 0 cleared, and mem_wdata[63:8] is zero.
- R3: After the byte write, a 64-bit read (mem_we=0, mem_wide=1) at desc_base+8 follows, then a 64-bit write of zero to desc_base+8.
- R4: Each access holds mem_req, mem_we, mem_wide, mem_addr and mem_wdata steady until mem_ack. The next access starts only after that acknowledge.
- R5: done is high for exactly one cycle, the cycle after the zero write is acknowledged. During that cycle merge_bits carries the 64-bit word that was fetched.
- R6: The cycle after done, pend_req equals its previous value ORed with the fetched word. No bit that was pending before is lost.
- R7: When the fetched word is zero, pend_req is unchanged, and done is still asserted.
- R8: pend_evt is high exactly when feat_en is high and pend_req is nonzero.
- R9: Start pulses that arrive while a sequence is busy (including its done cycle) are merged into one held request. That request launches exactly one further sequence after the current one completes.
- R10: After reset, mem_req, done and pend_evt are low and pend_req is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feat_en | input | 1 | Feature enable that gates the pending event |
| desc_base | input | ADDR_W | Descriptor base address |
| start | input | 1 | Notification arrival pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wide | output | 1 | 1 = 64-bit access, 0 = byte access |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | 64 | Write data (byte in bits 7:0) |
| mem_ack | input | 1 | Access acknowledge; read data is valid with it |
| mem_rdata | input | 64 | Read data (byte in bits 7:0) |
| done | output | 1 | One-cycle sequence completion |
| merge_bits | output | 64 | Fetched request bits, valid with done |
| pend_req | output | 64 | Pending request register |
| pend_evt | output | 1 | Pending user interrupt event |

## Verification
A sequencer stuck in a wrong step shows at the memory port at the very next request. The access type, width, address or write data then departs from the expected order, or mem_req fails to drop after done. A corrupted captured byte or word shows in the write data, or in merge_bits in the done cycle. A lost or duplicated held start shows as a missing or extra sequence within a few cycles of done. A merge that drops bits shows in pend_req and pend_evt one cycle after done.

// File: rtl/pn_pkg.sv
package pn_pkg;

    localparam int REQ_W      = 64;
    localparam int REQ_OFFSET = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_HDR,
        ST_WR_HDR,
        ST_RD_REQ,
        ST_WR_REQ,
        ST_DONE
    } pn_state_e;

    typedef struct packed {
        logic             req;
        logic             we;
        logic             wide;
        logic [REQ_W-1:0] wdata;
    } pn_access_t;

    function automatic logic [7:0] drop_outstanding(input logic [7:0] hdr);
        return hdr & 8'hFE;
    endfunction

    function automatic logic is_busy(input pn_state_e st);
        return st != ST_IDLE;
    endfunction

endpackage

// File: rtl/pn_seq.sv
module pn_seq
    import pn_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] desc_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [REQ_W-1:0]  mem_wdata,
    input  logic              mem_ack,
    input  logic [REQ_W-1:0]  mem_rdata,
    output logic              done,
    output logic [REQ_W-1:0]  fetched
);

    localparam logic [ADDR_W-1:0] WORD_OFS = ADDR_W'(REQ_OFFSET);

    pn_state_e        state_q;
    logic [7:0]       hdr_q;
    logic [REQ_W-1:0] word_q;
    logic             replay_q;
    pn_access_t       acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            hdr_q    <= '0;
            word_q   <= '0;
            replay_q <= 1'b0;
        end else begin
            if (!is_busy(state_q))
                replay_q <= 1'b0;
            else if (start)
                replay_q <= 1'b1;
            case (state_q)
                ST_IDLE:   if (start || replay_q) state_q <= ST_RD_HDR;
                ST_RD_HDR: if (mem_ack) begin
                    hdr_q   <= mem_rdata[7:0];
                    state_q <= ST_WR_HDR;
                end
                ST_WR_HDR: if (mem_ack) state_q <= ST_RD_REQ;
                ST_RD_REQ: if (mem_ack) begin
                    word_q  <= mem_rdata;
                    state_q <= ST_WR_REQ;
                end
                ST_WR_REQ: if (mem_ack) state_q <= ST_DONE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        acc = '0;
        case (state_q)
            ST_RD_HDR: acc.req = 1'b1;
            ST_WR_HDR: begin
                acc.req   = 1'b1;
                acc.we    = 1'b1;
                acc.wdata = {{(REQ_W-8){1'b0}}, drop_outstanding(hdr_q)};
            end
            ST_RD_REQ: begin
                acc.req  = 1'b1;
                acc.wide = 1'b1;
            end
            ST_WR_REQ: begin
                acc.req  = 1'b1;
                acc.we   = 1'b1;
                acc.wide = 1'b1;
            end
            default: acc = '0;
        endcase
    end

    assign mem_req   = acc.req;
    assign mem_we    = acc.we;
    assign mem_wide  = acc.wide;
    assign mem_wdata = acc.wdata;
    assign mem_addr  = acc.wide ? desc_base + WORD_OFS : desc_base;
    assign done      = (state_q == ST_DONE);
    assign fetched   = word_q;

    // R4: an unacknowledged access stays put
    a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_wide)
                                   && $stable(mem_wdata)));
    // R3: the header write is followed by the wide read
    a_r3_order_after_hdr: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && mem_we && !mem_wide) |=> (mem_req && !mem_we && mem_wide));
    // R5: single-cycle done, with no access alongside it
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r5_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req);

endmodule

// File: rtl/pn_merge.sv
module pn_merge
    import pn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             feat_en,
    input  logic             merge_en,
    input  logic [REQ_W-1:0] merge_bits,
    output logic [REQ_W-1:0] pend_req,
    output logic             pend_evt
);

    logic [REQ_W-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else if (merge_en)
            pend_q <= pend_q | merge_bits;
    end

    assign pend_req = pend_q;
    assign pend_evt = feat_en && (pend_q != '0);

    // R6: previously pending bits survive every cycle
    a_r6_keep_pending: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
    // R7: without a merge the register holds its value
    a_r7_hold_no_merge: assert property (@(posedge clk) disable iff (rst)
        !merge_en |=> $stable(pend_q));

endmodule

// File: rtl/posted_notify_drain.sv
module posted_notify_drain
    import pn_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              feat_en,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic              start,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [63:0]       mem_rdata,
    output logic              done,
    output logic [63:0]       merge_bits,
    output logic [63:0]       pend_req,
    output logic              pend_evt
);

    logic [REQ_W-1:0] fetched;

    pn_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .desc_base (desc_base),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_wide  (mem_wide),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .done      (done),
        .fetched   (fetched)
    );

    pn_merge u_merge (
        .clk        (clk),
        .rst        (rst),
        .feat_en    (feat_en),
        .merge_en   (done),
        .merge_bits (fetched),
        .pend_req   (pend_req),
        .pend_evt   (pend_evt)
    );

    assign merge_bits = fetched;

    // R8: event output tracks the register and the enable
    a_r8_evt_needs_pending: assert property (@(posedge clk) disable iff (rst)
        pend_evt |-> (feat_en && (pend_req != '0)));
    // R6: a done cycle grows the register by the fetched bits
    a_r6_merge_applied: assert property (@(posedge clk) disable iff (rst)
        done |=> ((pend_req & $past(merge_bits)) == $past(merge_bits)));

endmodule

// File: tb/posted_notify_drain_bench.sv
module posted_notify_drain_bench;

    localparam int AW = 32;

    typedef struct {
        logic          we;
        logic          wide;
        logic [AW-1:0] addr;
        logic [63:0]   wdata;
    } exp_acc_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          feat_en = 1'b1;
    logic [AW-1:0] desc_base = 32'h0000_1000;
    logic          start = 1'b0;
    logic          mem_req, mem_we, mem_wide, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_wdata, mem_rdata;
    logic          done, pend_evt;
    logic [63:0]   merge_bits, pend_req;

    int compared = 0;
    int mismatched = 0;
    int lat = 0;
    int wait_cnt = 0;
    int done_cnt = 0;
    logic waited = 1'b0;
    logic [AW-1:0] first_addr;
    logic [7:0]  mem_hdr;
    logic [63:0] mem_word;
    logic [63:0] pend_model = '0;
    logic        chk_pend = 1'b0;
    exp_acc_t    acc_q[$];
    logic [63:0] done_q[$];

    always #2 clk = ~clk;

    posted_notify_drain #(.ADDR_W(AW)) u_posted_notify_drain (
        .clk(clk), .rst(rst), .feat_en(feat_en), .desc_base(desc_base), .start(start),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done),
        .merge_bits(merge_bits), .pend_req(pend_req), .pend_evt(pend_evt)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model, scoreboard monitor
    always @(negedge clk) begin
        mem_ack <= 1'b0;
        if (chk_pend) begin
            chk_pend <= 1'b0;
            chk(pend_req == pend_model, "R6/R7 pend_req after merge", pend_req, pend_model);
        end
        if (!rst && done) begin
            if (done_q.size() == 0) begin
                chk(1'b0, "R9 unexpected done", 64'd1, 64'd0);
            end else begin
                logic [63:0] e;
                e = done_q.pop_front();
                chk(merge_bits == e, "R5 merge_bits at done", merge_bits, e);
                pend_model = pend_model | e;
                chk_pend <= 1'b1;
            end
            done_cnt++;
        end
        if (!rst && mem_req) begin
            if (wait_cnt == 0) begin
                exp_acc_t x;
                mem_ack <= 1'b1;
                wait_cnt = lat;
                if (waited)
                    chk(mem_addr == first_addr, "R4 addr stable until ack", mem_addr, first_addr);
                waited = 1'b0;
                if (acc_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected access", {32'd0, mem_addr}, 64'd0);
                end else begin
                    x = acc_q.pop_front();
                    chk(mem_we == x.we && mem_wide == x.wide && mem_addr == x.addr,
                        x.wide ? "R3 wide access kind/addr" : "R1/R2 byte access kind/addr",
                        {30'd0, mem_we, mem_wide, mem_addr}, {30'd0, x.we, x.wide, x.addr});
                    if (x.we)
                        chk(mem_wdata == x.wdata, x.wide ? "R3 zero write" : "R2 cleared byte",
                            mem_wdata, x.wdata);
                end
                if (mem_we && mem_wide) mem_word = mem_wdata;
                else if (mem_we)        mem_hdr  = mem_wdata[7:0];
                mem_rdata <= mem_wide ? mem_word : {56'd0, mem_hdr};
            end else begin
                if (!waited) first_addr = mem_addr;
                waited = 1'b1;
                wait_cnt--;
            end
        end
    end

    task automatic push_seq(input logic [7:0] hdr, input logic [63:0] word);
        acc_q.push_back('{1'b0, 1'b0, desc_base, 64'd0});
        acc_q.push_back('{1'b1, 1'b0, desc_base, {56'd0, hdr & 8'hFE}});
        acc_q.push_back('{1'b0, 1'b1, desc_base + 32'd8, 64'd0});
        acc_q.push_back('{1'b1, 1'b1, desc_base + 32'd8, 64'd0});
        done_q.push_back(word);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done(input int target);
        while (done_cnt < target) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run(input logic [7:0] hdr, input logic [63:0] word, input int l);
        int tgt;
        tgt = done_cnt + 1;
        lat = l; wait_cnt = l;
        mem_hdr = hdr; mem_word = word;
        push_seq(hdr, word);
        pulse_start();
        wait_done(tgt);
    endtask

    initial begin
        mem_ack = 1'b0; mem_rdata = '0; mem_hdr = '0; mem_word = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(mem_req == 1'b0, "R10 mem_req in reset", {63'd0, mem_req}, 64'd0);
        chk(done == 1'b0, "R10 done in reset", {63'd0, done}, 64'd0);
        chk(pend_req == 64'd0, "R10 pend_req in reset", pend_req, 64'd0);
        chk(pend_evt == 1'b0, "R10 pend_evt in reset", {63'd0, pend_evt}, 64'd0);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);

        // R1 R2 R3 R5 R6: zero latency, outstanding bit set
        run(8'h81, 64'h8000_0000_0000_0001, 0);
        chk(mem_hdr == 8'h80, "R2 memory byte cleared", {56'd0, mem_hdr}, 64'h80);
        chk(mem_word == 64'd0, "R3 memory word zeroed", mem_word, 64'd0);
        chk(pend_evt == 1'b1, "R8 event with pending", {63'd0, pend_evt}, 64'd1);

        // R4 R6: waited accesses, new base, bit 0 already clear
        desc_base = 32'h0000_2040;
        run(8'h40, 64'h0000_0000_0000_0003, 3);

        // R7: empty word leaves register alone
        run(8'h01, 64'd0, 1);
        chk(pend_req == 64'h8000_0000_0000_0003, "R7 register unchanged",
            pend_req, 64'h8000_0000_0000_0003);

        // R8: enable gates the event
        feat_en = 1'b0;
        @(negedge clk);
        chk(pend_evt == 1'b0, "R8 event off when disabled", {63'd0, pend_evt}, 64'd0);
        feat_en = 1'b1;
        @(negedge clk);
        chk(pend_evt == 1'b1, "R8 event on when enabled", {63'd0, pend_evt}, 64'd1);

        // R9: starts during busy coalesce into one replay
        begin
            int tgt;
            tgt = done_cnt + 2;
            lat = 2; wait_cnt = 2;
            mem_hdr = 8'h05; mem_word = 64'h0000_0000_0000_00F0;
            push_seq(8'h05, 64'h0000_0000_0000_00F0);
            push_seq(8'h04, 64'd0);
            pulse_start();
            repeat (2) @(negedge clk);
            pulse_start();
            @(negedge clk);
            pulse_start();
            wait_done(tgt);
            repeat (20) @(negedge clk);
            chk(done_cnt == tgt, "R9 exactly one replay", 64'(done_cnt), 64'(tgt));
            chk(mem_req == 1'b0, "R9 idle after replay", {63'd0, mem_req}, 64'd0);
            chk(acc_q.size() == 0, "R9 all accesses seen", 64'(acc_q.size()), 64'd0);
        end
        chk(pend_req == 64'h8000_0000_0000_00F3, "R6 accumulated register",
            pend_req, 64'h8000_0000_0000_00F3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(4 * 100000);
        compared++;
        mismatched++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule